// File: doc/BRIEF.md
# Bridge ADC Serial Readout Controller

This block is the host-side master for a bridge-sensor converter whose single output line does two jobs. While the line is idle-high, no data is waiting. A low level means a new conversion is ready. Once clocking starts, the same line carries the conversion bits. The controller watches that line through a two-stage synchronizer. When it sees the line low while reads are enabled, it issues serial clock pulses of a programmable half-period. It captures one bit per pulse, most significant bit first, sampling at the end of each low phase just before the next rising edge. By default it adds one more pulse after the last data bit, so that the converter drives the line high again and polling can resume cleanly.

The 24-bit two's complement word is sign-extended to 32 bits and presented with a one-cycle strobe. After reset, after a restart request (for example when an external input selector has switched) and after leaving standby, a programmable number of completed frames is dropped because the converter's filter has not yet settled. The host can park the serial clock high to put the converter into standby. Releasing the request drives the clock low again, which wakes the converter. A readout that takes longer than a programmed cycle budget raises an overrun pulse and is abandoned.

Top module: `brx_readout`

## Requirements
- R1: After reset, sclk, busy, result_vld and overrun are 0 and result is 0.
- R2: While run is 0, or while the synchronized data line is high, no serial clock pulse is issued.
- R3: During a readout every sclk high phase and every sclk low phase between pulses lasts exactly HALF_CYC system clocks.
- R4: The 24 bits are shifted in MSB first, each sampled at the end of a low phase. The reported result is the 24-bit two's complement value sign-extended to 32 bits (bit 23 copied into bits 31..24).
- R5: With EXTRA_PULSE=1 (the default), each frame has exactly 25 rising sclk edges: 24 for data and one that returns the line high.
- R6: Each reported frame produces exactly one result_vld cycle. result changes only together with that strobe.
- R7: After reset the first SKIP_CNT (default 4) completed frames are dropped with no strobe, and the next frame is reported.
- R8: A one-cycle restart pulse reloads the drop count, so the next SKIP_CNT frames are dropped and the one after them is reported. A restart in the same cycle as a frame completion suppresses that frame's strobe.
- R9: While sleep_req is 1 and no readout is in progress, sclk is held high and busy is 0. When sleep_req falls, sclk returns low and the drop count is reloaded.
- R10: If 24 bits are not captured within TIMEOUT_CYC cycles of the first pulse, overrun pulses for one cycle, the readout is abandoned (busy falls) and no result is strobed.
- R11: busy is 1 from the first rising sclk edge of a frame through the completion cycle. With EXTRA_PULSE=1 that is 50*HALF_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Shared ready/data line from the converter (asynchronous) |
| run | input | 1 | Enables continuous polling and readout |
| restart | input | 1 | Reloads the settle-drop count |
| sleep_req | input | 1 | Requests standby by holding sclk high |
| sclk | output | 1 | Serial clock to the converter |
| result | output | 32 | Last reported sample, sign-extended |
| result_vld | output | 1 | One-cycle strobe for a new result |
| busy | output | 1 | Readout in progress |
| overrun | output | 1 | One-cycle pulse when the readout budget is exceeded |

## Verification
The bench models the converter at the pin level and drives the MSB first on each rising sclk. It aims at the sign boundary words (0x7FFFFF, 0x800000, 0xFFFFFF), where a design that dropped or zero-filled the upper byte would report a large positive value in place of a small negative one. It counts pulses per frame and the width of each phase: a design without the trailing pulse would leave a low data bit on the line and re-trigger on it. A design that miscounts the drop window would strobe one frame early or late after reset, after a restart and after standby. A second instance with a deliberately short budget, and the line stuck low, must only ever report overruns.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int DATA_W = 24;
  localparam int OUT_W  = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_HI, S_LO, S_XHI, S_XLO, S_DONE, S_STBY
  } rd_state_t;

  // Copy the sign bit of the captured word into the upper bits.
  function automatic logic [OUT_W-1:0] widen(input logic [DATA_W-1:0] w);
    return {{(OUT_W-DATA_W){w[DATA_W-1]}}, w};
  endfunction
endpackage

// File: rtl/brx_phase_timer.sv
module brx_phase_timer #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(HALF_CYC)); // R3
endmodule

// File: rtl/brx_shift_in.sv
module brx_shift_in #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         last
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] n;

  assign last = (n == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      n    <= '0;
    end else if (clr) begin
      n <= '0;
    end else if (take) begin
      word <= {word[W-2:0], din};
      n    <= n + 1'b1;
    end
  end

  AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    n <= CW'(W)); // R4
endmodule

// File: rtl/brx_discard.sv
module brx_discard #(
  parameter int SKIP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic consume,
  output logic drop
);
  localparam int CW = $clog2(SKIP + 2);

  logic [CW-1:0] cnt;

  assign drop = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= CW'(SKIP);
    else if (reload)           cnt <= CW'(SKIP);
    else if (consume && drop)  cnt <= cnt - 1'b1;
  end

  generate
    if (SKIP > 0) begin : g_chk
      AST_RELOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> drop); // R8
    end
  endgenerate
endmodule

// File: rtl/brx_readout.sv
module brx_readout #(
  parameter int HALF_CYC    = 25,
  parameter int SKIP_CNT    = 4,
  parameter int TIMEOUT_CYC = 3_125_000,
  parameter bit EXTRA_PULSE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sdi,
  input  logic                       run,
  input  logic                       restart,
  input  logic                       sleep_req,
  output logic                       sclk,
  output logic [brx_pkg::OUT_W-1:0]  result,
  output logic                       result_vld,
  output logic                       busy,
  output logic                       overrun
);
  import brx_pkg::*;

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  rd_state_t          state, nxt, after_last;
  logic               sdi_m, sdi_s, line_low;
  logic               tick, tmr_clr, take, last, shf_clr;
  logic [DATA_W-1:0]  word;
  logic               drop, reload, frame_done, wake;
  logic               in_bits, tout_evt;
  logic [TW-1:0]      tcnt;

  // Data line crosses from the converter's domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdi_m <= 1'b1;
      sdi_s <= 1'b1;
    end else begin
      sdi_m <= sdi;
      sdi_s <= sdi_m;
    end
  end
  assign line_low = !sdi_s;

  // Named events for the checks below.
  assign in_bits    = (state == S_HI) || (state == S_LO);
  assign frame_done = (state == S_DONE);
  assign wake       = (state == S_STBY) && !sleep_req;
  assign take       = (state == S_LO) && tick;
  assign shf_clr    = (state == S_WAIT);
  assign tmr_clr    = !(in_bits || (state == S_XHI) || (state == S_XLO));
  assign tout_evt   = in_bits && (tcnt == TW'(TIMEOUT_CYC - 1));
  assign reload     = restart || wake || tout_evt;

  generate
    if (EXTRA_PULSE) begin : g_extra
      assign after_last = S_XHI;
    end else begin : g_plain
      assign after_last = S_DONE;
    end
  endgenerate

  brx_phase_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
  );

  brx_shift_in #(.W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .clr(shf_clr), .take(take),
    .din(sdi_s), .word(word), .last(last)
  );

  brx_discard #(.SKIP(SKIP_CNT)) u_skip (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .consume(frame_done), .drop(drop)
  );

  // Readout budget, counted only while data bits are outstanding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt <= '0;
    else if (!in_bits) tcnt <= '0;
    else if (!tout_evt) tcnt <= tcnt + 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (sleep_req) nxt = S_STBY;
              else if (run)  nxt = S_WAIT;
      S_WAIT: if (sleep_req)     nxt = S_STBY;
              else if (!run)     nxt = S_IDLE;
              else if (line_low) nxt = S_HI;
      S_HI:   if (tout_evt)  nxt = S_IDLE;
              else if (tick) nxt = S_LO;
      S_LO:   if (tout_evt)  nxt = S_IDLE;
              else if (tick) nxt = last ? after_last : S_HI;
      S_XHI:  if (tick) nxt = S_XLO;
      S_XLO:  if (tick) nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      S_STBY: if (!sleep_req) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sclk       <= 1'b0;
      busy       <= 1'b0;
      result     <= '0;
      result_vld <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      state      <= nxt;
      sclk       <= (nxt == S_HI) || (nxt == S_XHI) || (nxt == S_STBY);
      busy       <= (nxt == S_HI) || (nxt == S_LO) || (nxt == S_XHI) ||
                    (nxt == S_XLO) || (nxt == S_DONE);
      result_vld <= frame_done && !drop && !restart;
      overrun    <= tout_evt;
      if (frame_done && !drop && !restart) result <= widen(word);
    end
  end

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld); // R6
  AST_VLD_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $past(frame_done)); // R6
  AST_NO_VLD_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> !$past(drop)); // R7
  AST_WAIT_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sclk); // R2
  AST_STANDBY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_STBY) && $past(state == S_STBY)) |-> (sclk && !busy)); // R9
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sclk != $past(sclk))) |-> $past(tick)); // R3
  AST_OVERRUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (!busy && !result_vld)); // R10
endmodule

// File: tb/brx_readout_tb.sv
module brx_readout_tb;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run, restart, sleep_req;
  logic sclk, result_vld, busy, overrun;
  logic [31:0] result;

  // Converter model state
  logic [23:0] cur;
  logic        armed;
  int          edges, base, k;
  logic        line;

  always @(posedge sclk) edges++;
  always_comb k = edges - base;
  assign line = !armed ? 1'b1 : (k == 0) ? 1'b0 : (k <= 24) ? cur[24-k] : 1'b1;

  brx_readout #(.HALF_CYC(HALF), .SKIP_CNT(4), .TIMEOUT_CYC(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .sdi(line), .run(run), .restart(restart),
    .sleep_req(sleep_req), .sclk(sclk), .result(result),
    .result_vld(result_vld), .busy(busy), .overrun(overrun)
  );

  // Second instance: budget too short for a 24-bit readout, line stuck low.
  logic        o_sclk, o_vld, o_busy, o_ovr;
  logic [31:0] o_res;
  brx_readout #(.HALF_CYC(HALF), .SKIP_CNT(0), .TIMEOUT_CYC(20)) u_ovr (
    .clk(clk), .rst_n(rst_n), .sdi(1'b0), .run(run), .restart(1'b0),
    .sleep_req(1'b0), .sclk(o_sclk), .result(o_res),
    .result_vld(o_vld), .busy(o_busy), .overrun(o_ovr)
  );

  int total = 0, bad = 0;
  int vld_cnt = 0, busy_cyc = 0, hi_runs = 0, hi_bad = 0, lo_bad = 0;
  int ovr_cnt = 0, ovr_vld = 0, run_len = 0;
  logic prev_s = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (result_vld) vld_cnt++;
    if (o_ovr) ovr_cnt++;
    if (o_vld) ovr_vld++;
    if (busy) begin
      busy_cyc++;
      if (sclk == prev_s) run_len++;
      else begin
        if (run_len > 0) begin
          if (prev_s) begin hi_runs++; if (run_len != HALF) hi_bad++; end
          else if (run_len != HALF) lo_bad++;
        end
        run_len = 1;
      end
    end else run_len = 0;
    prev_s = sclk;
  end

  // stimulus / expected: {word, sign-extended value}
  localparam logic [55:0] VEC [6] = '{
    {24'h000000, 32'h0000_0000},
    {24'h000001, 32'h0000_0001},
    {24'hFFFFFF, 32'hFFFF_FFFF},
    {24'h7FFFFF, 32'h007F_FFFF},
    {24'h800000, 32'hFF80_0000},
    {24'hA5C3E1, 32'hFFA5_C3E1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [23:0] w);
    cur   = w;
    base  = edges;
    armed = 1'b1;
  endtask

  task automatic do_frame(input logic [23:0] w);
    present(w);
    wait (busy);
    wait (!busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0, v0, b0, h0;
    logic [31:0] last_res;
    rst_n = 1'b0; run = 1'b0; restart = 1'b0; sleep_req = 1'b0;
    armed = 1'b0; cur = '0; base = 0; edges = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sclk, busy, result_vld, overrun} == 4'b0, "R1",
        {28'd0, sclk, busy, result_vld, overrun}, 32'd0);
    chk(result == 32'd0, "R1", result, 32'd0);

    // R2: line low but run off -> no pulses
    present(24'h123456);
    repeat (40) @(negedge clk);
    chk(edges == 0, "R2", edges, 0);
    chk(busy == 1'b0, "R2", {31'd0, busy}, 32'd0);

    // First frame: widths, pulse count, busy length; dropped (R7)
    e0 = edges; v0 = vld_cnt; b0 = busy_cyc; h0 = hi_runs;
    run = 1'b1;
    wait (busy); wait (!busy); repeat (3) @(negedge clk);
    chk(edges - e0 == 25, "R5", edges - e0, 25);
    chk(hi_bad == 0 && hi_runs - h0 == 25, "R3", hi_bad, 0);
    chk(lo_bad == 0, "R3", lo_bad, 0);
    chk(busy_cyc - b0 == 50*HALF + 1, "R11", busy_cyc - b0, 50*HALF + 1);
    chk(vld_cnt == v0, "R7", vld_cnt - v0, 0);

    // R2: line high while running -> no pulses
    e0 = edges;
    repeat (40) @(negedge clk);
    chk(edges == e0, "R2", edges - e0, 0);

    for (int i = 0; i < 3; i++) begin
      v0 = vld_cnt;
      do_frame(24'h5A5A5A);
      chk(vld_cnt == v0, "R7", vld_cnt - v0, 0);
    end

    // Table walk: each frame now reported
    for (int i = 0; i < 6; i++) begin
      v0 = vld_cnt;
      do_frame(VEC[i][55:32]);
      chk(vld_cnt - v0 == 1, "R6", vld_cnt - v0, 1);
      chk(result == VEC[i][31:0], "R4", result, VEC[i][31:0]);
    end

    // R8: restart reloads the drop window
    @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
    last_res = result;
    for (int i = 0; i < 4; i++) begin
      v0 = vld_cnt;
      do_frame(24'h010203 + 24'(i));
      chk(vld_cnt == v0, "R8", vld_cnt - v0, 0);
    end
    chk(result == last_res, "R6", result, last_res);
    v0 = vld_cnt;
    do_frame(24'hC00001);
    chk(vld_cnt - v0 == 1, "R8", vld_cnt - v0, 1);
    chk(result == 32'hFFC0_0001, "R4", result, 32'hFFC0_0001);

    // R9: standby holds sclk high, busy low
    sleep_req = 1'b1;
    repeat (5) @(negedge clk);
    h0 = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!sclk || busy) h0++;
    end
    chk(h0 == 0, "R9", h0, 0);
    sleep_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R9", {31'd0, sclk}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      v0 = vld_cnt;
      do_frame(24'h0F0F0F);
      chk(vld_cnt == v0, "R9", vld_cnt - v0, 0);
    end
    v0 = vld_cnt;
    do_frame(24'h3C3C3C);
    chk(vld_cnt - v0 == 1, "R9", vld_cnt - v0, 1);
    chk(result == 32'h003C_3C3C, "R4", result, 32'h003C_3C3C);

    // R10: short-budget instance only ever overruns
    chk(ovr_cnt > 0, "R10", ovr_cnt, 1);
    chk(ovr_vld == 0, "R10", ovr_vld, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule